// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Operation Decoder

This block is a purely combinational arithmetic-logic unit together with the small decoder that chooses its operation. A main controller supplies a 2-bit operation class. The class either forces an addition, forces a subtraction, or tells the decoder to take the operation from the 6-bit function field of the current instruction. The decoder turns this into a 3-bit operation select.

The unit applies the selected operation to two operands of `DATA_W` bits (32 by default). It returns the result, a zero flag and a signed overflow flag. The select is also driven out, so that the surrounding datapath can see which operation was chosen.

Add, subtract and set-on-less-than all share one adder, which runs in subtract mode whenever bit 2 of the select is set. A parameter picks how the adder is built: an explicit ripple-carry chain, or a behavioural sum. The block has no clock and no reset. Every output follows its inputs within the same cycle.

Top module: `arith_unit`

## Requirements
- R1: Class code 00 produces select 010 (add), whatever the function field holds.
- R2: Class code 01 produces select 110 (subtract), whatever the function field holds.
- R3: Under class code 10 the function field sets the select. 100000 gives add (010), 100010 gives subtract (110), 100100 gives AND (000), 100101 gives OR (001), and 101010 gives set-on-less-than (111).
- R4: Under class code 10, a function field that is not listed in R3 gives add (010). Class code 11 also gives add.
- R5: Select 000 outputs the bitwise AND of the operands, and select 001 outputs their bitwise OR.
- R6: Select 010 outputs A+B and select 110 outputs A-B, both modulo 2^DATA_W.
- R7: On add, overflow is 1 exactly when both operands have the same sign and the result's sign differs from it.
- R8: On subtract, overflow is 1 exactly when the operands have different signs and the result's sign differs from the sign of A.
- R9: Overflow is 0 for AND, OR and set-on-less-than, even when A-B would overflow.
- R10: Select 111 outputs 1 when A < B as signed two's-complement values, and 0 otherwise. The comparison stays correct when A-B overflows.
- R11: The zero flag is 1 exactly when every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | DATA_W | First operand (A) |
| opnd_b | input | DATA_W | Second operand (B) |
| sel_out | output | 3 | Decoded operation select |
| result | output | DATA_W | Operation result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds the unit with DATA_W = 32 and the ripple-carry variant (RIPPLE = 1). This is the variant in which a carry that goes wrong at any bit position can show up in the result or in the overflow flag. At 32 bits, the signed extremes 0x7FFFFFFF and 0x80000000 are easy to reach. Against these values the bench checks overflow in both directions, sums that wrap to zero, and the overflow correction of set-on-less-than. Each function code is also driven under each class code, so the bench can confirm that the class code alone decides between forcing an operation and deferring to the function field.

// File: rtl/arith_pkg.sv
package arith_pkg;

    localparam int FUNCT_W = 6;
    localparam int SEL_W   = 3;
    localparam int CLASS_W = 2;

    // Operation select; bit 2 set means the shared adder subtracts
    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 3'b000,
        SEL_OR  = 3'b001,
        SEL_ADD = 3'b010,
        SEL_SUB = 3'b110,
        SEL_SLT = 3'b111
    } alu_sel_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_RSVD  = 2'b11
    } op_class_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    // Adder control derived from a select
    typedef struct packed {
        logic subtract;
        logic arith;
    } adder_ctl_t;

    function automatic adder_ctl_t ctl_of(alu_sel_e s);
        adder_ctl_t c;
        c.subtract = s[2];
        c.arith    = (s == SEL_ADD) || (s == SEL_SUB);
        return c;
    endfunction

    function automatic alu_sel_e funct_to_sel(logic [FUNCT_W-1:0] f);
        alu_sel_e s;
        case (f)
            FN_ADD:  s = SEL_ADD;
            FN_SUB:  s = SEL_SUB;
            FN_AND:  s = SEL_AND;
            FN_OR:   s = SEL_OR;
            FN_SLT:  s = SEL_SLT;
            default: s = SEL_ADD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import arith_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNCT_W-1:0] funct,
    output alu_sel_e           sel
);

    always_comb begin
        case (op_class_e'(op_class))
            CLS_ADD:   sel = SEL_ADD;
            CLS_SUB:   sel = SEL_SUB;
            CLS_FUNCT: sel = funct_to_sel(funct);
            default:   sel = SEL_ADD;
        endcase
    end

    always_comb begin
        // R1
        dec_class_add_chk: assert (op_class != 2'b00 || sel == SEL_ADD);
        // R2
        dec_class_sub_chk: assert (op_class != 2'b01 || sel == SEL_SUB);
        // R4
        dec_rsvd_class_chk: assert (op_class != 2'b11 || sel == SEL_ADD);
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw,
    output logic              lt
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    assign b_eff = sub ? ~b : b;

    generate
        if (RIPPLE) begin : g_ripple
            logic [DATA_W:0] carry;
            assign carry[0] = sub;
            for (genvar i = 0; i < DATA_W; i++) begin : g_bit
                assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
                assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
            end
            assign ovf_raw = carry[DATA_W] ^ carry[DATA_W-1];
        end else begin : g_behav
            assign sum     = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
            assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        end
    endgenerate

    // Sign of the true difference: result sign corrected by overflow
    assign lt = sum[MSB] ^ ovf_raw;

    always_comb begin
        // R6
        addsub_value_chk: assert (sum == (sub ? (a - b) : (a + b)));
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              pick_or,
    output logic [DATA_W-1:0] y
);

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_lbit
            assign y[i] = pick_or ? (a[i] | b[i]) : (a[i] & b[i]);
        end
    endgenerate

endmodule

// File: rtl/arith_unit.sv
module arith_unit
    import arith_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [1:0]        op_class,
    input  logic [5:0]        funct,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [2:0]        sel_out,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              ovf
);

    alu_sel_e          sel;
    adder_ctl_t        ctl;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] logic_y;
    logic              ovf_raw;
    logic              lt;

    alu_op_decoder u_dec (
        .op_class (op_class),
        .funct    (funct),
        .sel      (sel)
    );

    assign ctl = ctl_of(sel);

    alu_addsub #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_addsub (
        .a       (opnd_a),
        .b       (opnd_b),
        .sub     (ctl.subtract),
        .sum     (sum),
        .ovf_raw (ovf_raw),
        .lt      (lt)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a       (opnd_a),
        .b       (opnd_b),
        .pick_or (sel[0]),
        .y       (logic_y)
    );

    always_comb begin
        case (sel)
            SEL_AND, SEL_OR: result = logic_y;
            SEL_SLT:         result = {{(DATA_W-1){1'b0}}, lt};
            default:         result = sum;
        endcase
    end

    assign zero    = ~|result;
    assign ovf     = ctl.arith & ovf_raw;
    assign sel_out = sel;

    always_comb begin
        // R9
        no_overflow_chk: assert (ctl.arith || !ovf);
        // R10
        slt_upper_chk: assert (sel != SEL_SLT || result[DATA_W-1:1] == '0);
        // R11
        slt_zero_chk: assert (sel != SEL_SLT || zero == !lt);
        // R5
        and_subset_chk: assert (sel != SEL_AND || (result & ~opnd_a) == '0);
    end

endmodule

// File: tb/arith_unit_bench.sv
module arith_unit_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op_class = 2'b00;
    logic [5:0]   funct = 6'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [2:0]   sel_out;
    logic [W-1:0] result;
    logic         zero;
    logic         ovf;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    arith_unit #(.DATA_W(W), .RIPPLE(1'b1)) u_arith_unit (
        .op_class (op_class),
        .funct    (funct),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .sel_out  (sel_out),
        .result   (result),
        .zero     (zero),
        .ovf      (ovf)
    );

    // Expected select, from the class and function encodings
    function automatic logic [2:0] exp_sel(logic [1:0] c, logic [5:0] f);
        if (c == 2'b00) return 3'b010;
        if (c == 2'b01) return 3'b110;
        if (c == 2'b11) return 3'b010;
        case (f)
            6'b100000: return 3'b010;
            6'b100010: return 3'b110;
            6'b100100: return 3'b000;
            6'b100101: return 3'b001;
            6'b101010: return 3'b111;
            default:   return 3'b010;
        endcase
    endfunction

    task automatic apply_and_check(input logic [1:0] c, input logic [5:0] f,
                                   input logic [W-1:0] a, input logic [W-1:0] b,
                                   input string tag);
        logic [2:0]        es;
        logic signed [W:0] wide;
        logic [W-1:0]      er;
        logic              eo;
        @(negedge clk);
        op_class = c; funct = f; opnd_a = a; opnd_b = b;
        @(posedge clk);
        #1;
        es = exp_sel(c, f);
        eo = 1'b0;
        case (es)
            3'b000: er = a & b;
            3'b001: er = a | b;
            3'b110: begin
                wide = $signed({a[W-1], a}) - $signed({b[W-1], b});
                er = wide[W-1:0];
                eo = wide[W] != wide[W-1];
            end
            3'b111: er = ($signed(a) < $signed(b)) ? 1 : 0;
            default: begin
                wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
                er = wide[W-1:0];
                eo = wide[W] != wide[W-1];
            end
        endcase
        total++;
        if (sel_out !== es || result !== er || ovf !== eo || zero !== (er == '0)) begin
            bad++;
            $display("FAIL %s: sel=%b res=%h z=%b ov=%b expected sel=%b res=%h z=%b ov=%b",
                     tag, sel_out, result, zero, ovf, es, er, (er == '0), eo);
        end
    endtask

    task automatic t_idle_state();
        @(posedge clk); #1;
        total++;
        if (sel_out !== 3'b010 || result !== '0 || zero !== 1'b1 || ovf !== 1'b0) begin
            bad++;
            $display("FAIL R11 idle: sel=%b res=%h z=%b ov=%b expected sel=010 res=0 z=1 ov=0",
                     sel_out, result, zero, ovf);
        end
    endtask

    task automatic t_forced_classes();
        apply_and_check(2'b00, 6'b100100, 32'h0000_0005, 32'h0000_0003, "R1 class00 ignores AND fn");
        apply_and_check(2'b00, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, "R1 class00 ignores SLT fn");
        apply_and_check(2'b01, 6'b100000, 32'h0000_0005, 32'h0000_0003, "R2 class01 ignores ADD fn");
        apply_and_check(2'b01, 6'b100101, 32'h0000_0003, 32'h0000_0005, "R2 class01 ignores OR fn");
    endtask

    task automatic t_funct_decode();
        apply_and_check(2'b10, 6'b100000, 32'h1234_5678, 32'h1111_1111, "R3 fn add");
        apply_and_check(2'b10, 6'b100010, 32'h1234_5678, 32'h1111_1111, "R3 fn sub");
        apply_and_check(2'b10, 6'b100100, 32'hF0F0_FF00, 32'hFF00_0FF0, "R3 R5 fn and");
        apply_and_check(2'b10, 6'b100101, 32'hF0F0_0000, 32'h0F00_000F, "R3 R5 fn or");
        apply_and_check(2'b10, 6'b101010, 32'h0000_0002, 32'h0000_0009, "R3 fn slt");
    endtask

    task automatic t_defaults();
        apply_and_check(2'b10, 6'b000000, 32'h0000_0010, 32'h0000_0020, "R4 undefined fn 000000");
        apply_and_check(2'b10, 6'b100111, 32'h7FFF_FFFF, 32'h0000_0001, "R4 undefined fn 100111");
        apply_and_check(2'b11, 6'b100010, 32'h0000_0007, 32'h0000_0009, "R4 class11 gives add");
    endtask

    task automatic t_add_sub_wrap();
        apply_and_check(2'b00, 6'b0, 32'hFFFF_FFFF, 32'h0000_0001, "R6 R7 add wraps to zero, no ovf");
        apply_and_check(2'b01, 6'b0, 32'h0000_0000, 32'h0000_0001, "R6 sub borrows to all ones");
        apply_and_check(2'b01, 6'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R6 R11 equal sub gives zero");
    endtask

    task automatic t_overflow();
        apply_and_check(2'b00, 6'b0, 32'h7FFF_FFFF, 32'h0000_0001, "R7 positive add overflow");
        apply_and_check(2'b00, 6'b0, 32'h8000_0000, 32'h8000_0000, "R7 R11 negative add overflow to zero");
        apply_and_check(2'b00, 6'b0, 32'h7FFF_FFFF, 32'h8000_0000, "R7 mixed signs no overflow");
        apply_and_check(2'b01, 6'b0, 32'h8000_0000, 32'h0000_0001, "R8 sub overflow negative side");
        apply_and_check(2'b01, 6'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8 sub overflow positive side");
        apply_and_check(2'b01, 6'b0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R8 same sign sub no overflow");
    endtask

    task automatic t_logic_no_ovf();
        apply_and_check(2'b10, 6'b100100, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9 and no ovf");
        apply_and_check(2'b10, 6'b100101, 32'h8000_0000, 32'h8000_0000, "R9 or no ovf");
        apply_and_check(2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001, "R9 slt no ovf");
        apply_and_check(2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555, "R11 and to zero");
    endtask

    task automatic t_slt_signed();
        apply_and_check(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, "R10 -1 < 1");
        apply_and_check(2'b10, 6'b101010, 32'h0000_0001, 32'hFFFF_FFFF, "R10 1 < -1 false");
        apply_and_check(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R10 min < max with overflow");
        apply_and_check(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R10 max < min false with overflow");
        apply_and_check(2'b10, 6'b101010, 32'h8000_0000, 32'h8000_0000, "R10 equal false");
        apply_and_check(2'b10, 6'b101010, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R10 -2 < -1");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle_state();
        t_forced_classes();
        t_funct_decode();
        t_defaults();
        t_add_sub_wrap();
        t_overflow();
        t_logic_no_ovf();
        t_slt_signed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule